// File: doc/BRIEF.md
# Banked System Memory Decoder

This block sits between a CPU core and its on-chip memories in a 16-bit byte-addressed space. For each request it classifies the address and steers the access to one target. The targets are a video RAM with two banks, a work RAM whose upper 4 KiB window selects one of several banks, an object attribute store, and a 256-byte high store that holds the I/O registers and fast RAM. Cartridge addresses go out on a mapper port in the same cycle, and the mapper's answer is taken back in that cycle.

Every request gets its answer one clock later on `resp_o`, with read data on `rdata_o`. A low `resp_o` means "no response", which is a different outcome from a read that returns 0x00. Two bank-select registers sit in the I/O area. Each one reads back zero-extended.

The backing depth of the video and work RAM banks is set by the `VRAM_AW` and `WRAM_AW` parameters. Full size is 13 and 12 address bits. With a smaller value, each bank window aliases onto its backing store.

Top module: `sysmem_decode`

## Requirements
- R1: A request in cycle t is answered in cycle t+1. `resp_o` is 1 only for mapped regions, and a cycle without a request gives `resp_o`=0. When a read gets no response or a write is answered, `rdata_o` is 0.
- R2: Requests at 0x0000–0x7FFF and 0xA000–0xBFFF drive `cart_req_o`, `cart_we_o`, `cart_addr_o` (the full address) and `cart_wdata_o` in the request cycle. In that same cycle `cart_ack_i` and `cart_rdata_i` are sampled, and they become `resp_o` and `rdata_o` in the next cycle.
- R3: 0x8000–0x9FFF is video RAM. The bank is picked by bit 0 of the video bank register, and the two banks hold separate data.
- R4: 0xC000–0xCFFF is a fixed work RAM bank. The bank register does not affect it.
- R5: 0xD000–0xDFFF takes its bank from the 3-bit work bank register. A register value of 0 selects bank 1.
- R6: 0xFE00–0xFE9F is object attribute storage. Reads and writes there are acknowledged, and written bytes read back.
- R7: 0xFEA0–0xFEFF is illegal. Reads and writes there get no response, and a write there changes no storage.
- R8: 0xE000–0xFDFF is unmapped and gets no response.
- R9: 0xFF00–0xFFFF is one 256-byte store indexed by address bits [7:0], apart from the two bank register offsets.
- R10: The video bank register is at 0xFF6E (bit 0) and the work bank register is at 0xFF6F (bits [2:0]). Writes keep only those bits, and reads return them zero-extended.
- R11: Reset clears both bank registers and every byte of the high store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Byte address |
| wdata_i | input | 8 | Write data |
| resp_o | output | 1 | Access answered (one cycle after the request) |
| rdata_o | output | 8 | Read data (one cycle after the request) |
| cart_req_o | output | 1 | Cartridge access request |
| cart_we_o | output | 1 | Cartridge write |
| cart_addr_o | output | 16 | Cartridge address |
| cart_wdata_o | output | 8 | Cartridge write data |
| cart_ack_i | input | 1 | Mapper accepted the access (same cycle) |
| cart_rdata_i | input | 8 | Mapper read data (same cycle) |

## Verification
The assertions check on every cycle that idle cycles and accesses to illegal or unmapped addresses give no response. They also check that at most one storage write enable is active, that a RAM's read port holds its value when it is not read, and that each bank register takes the written value. Only the bench scenarios can show that bank selection separates the data, that a work bank value of 0 aliases bank 1, and that the lower work RAM stays fixed. The same holds for the contents after reset and for a full sweep of all 65,536 addresses, each of which must be classified into the right response.

// File: rtl/sysmem_pkg.sv
package sysmem_pkg;
  typedef enum logic [2:0] {
    RG_NONE,
    RG_CART,
    RG_VRAM,
    RG_WRAM,
    RG_OAM,
    RG_HIGH,
    RG_VBANK,
    RG_WBANK
  } region_e;

  localparam logic [7:0] OFS_VBANK = 8'h6E;
  localparam logic [7:0] OFS_WBANK = 8'h6F;
  localparam int unsigned OAM_BYTES  = 160;
  localparam int unsigned HIGH_BYTES = 256;
endpackage

// File: rtl/sysmem_addr_dec.sv
module sysmem_addr_dec
  import sysmem_pkg::*;
(
  input  logic [15:0] addr_i,
  output region_e     region_o
);
  always_comb begin
    region_o = RG_NONE;
    if (addr_i <= 16'h7FFF)                             region_o = RG_CART;
    else if (addr_i <= 16'h9FFF)                        region_o = RG_VRAM;
    else if (addr_i <= 16'hBFFF)                        region_o = RG_CART;
    else if (addr_i <= 16'hDFFF)                        region_o = RG_WRAM;
    else if (addr_i >= 16'hFE00 && addr_i <= 16'hFE9F)  region_o = RG_OAM;
    else if (addr_i >= 16'hFF00) begin
      if (addr_i[7:0] == OFS_VBANK)      region_o = RG_VBANK;
      else if (addr_i[7:0] == OFS_WBANK) region_o = RG_WBANK;
      else                               region_o = RG_HIGH;
    end
  end
endmodule

// File: rtl/sysmem_bank_sel.sv
module sysmem_bank_sel #(
  parameter int unsigned WBANK_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_vbank_i,
  input  logic               wr_wbank_i,
  input  logic [WBANK_W-1:0] wdata_i,
  output logic               vbank_o,
  output logic [WBANK_W-1:0] wbank_o,
  output logic [WBANK_W-1:0] wbank_eff_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vbank_o <= 1'b0;
      wbank_o <= '0;
    end else begin
      if (wr_vbank_i) vbank_o <= wdata_i[0];
      if (wr_wbank_i) wbank_o <= wdata_i;
    end
  end

  // bank 0 is the fixed lower half; select value 0 maps to bank 1
  assign wbank_eff_o = (wbank_o == '0) ? WBANK_W'(1) : wbank_o;

  a_r10_vbank_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vbank_i |=> vbank_o == $past(wdata_i[0]));
  a_r10_wbank_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_wbank_i |=> wbank_o == $past(wdata_i));
endmodule

// File: rtl/sysmem_byte_ram.sv
module sysmem_byte_ram #(
  parameter int unsigned DEPTH     = 256,
  parameter bit          CLEAR_RST = 1'b0,
  localparam int unsigned AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  generate
    if (CLEAR_RST) begin : g_clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= 8'h00;
        end else if (we_i) begin
          mem_q[addr_i] <= wdata_i;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk_i) begin
        if (we_i) mem_q[addr_i] <= wdata_i;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= 8'h00;
    else if (re_i) rdata_o <= mem_q[addr_i];
  end

  a_r1_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

// File: rtl/sysmem_decode.sv
module sysmem_decode
  import sysmem_pkg::*;
#(
  parameter int unsigned VRAM_AW = 6,
  parameter int unsigned WRAM_AW = 6,
  parameter int unsigned WBANK_W = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [15:0] addr_i,
  input  logic [7:0]  wdata_i,
  output logic        resp_o,
  output logic [7:0]  rdata_o,
  output logic        cart_req_o,
  output logic        cart_we_o,
  output logic [15:0] cart_addr_o,
  output logic [7:0]  cart_wdata_o,
  input  logic        cart_ack_i,
  input  logic [7:0]  cart_rdata_i
);
  localparam int unsigned VRAM_DEPTH = 2 * (1 << VRAM_AW);
  localparam int unsigned WRAM_DEPTH = (1 << WBANK_W) * (1 << WRAM_AW);
  localparam int unsigned VIDX_W     = VRAM_AW + 1;
  localparam int unsigned WIDX_W     = VRAM_AW > 0 ? WRAM_AW + WBANK_W : WBANK_W;

  region_e rg;
  logic rd, wr, is_cart, mapped;
  logic vram_we, vram_re, wram_we, wram_re, oam_we, oam_re, high_we, high_re;
  logic wr_vbank, wr_wbank;
  logic vbank;
  logic [WBANK_W-1:0] wbank, wbank_eff, wram_bank;
  logic [VIDX_W-1:0] vram_idx;
  logic [WIDX_W-1:0] wram_idx;
  logic [7:0] vram_q, wram_q, oam_q, high_q;

  region_e    rg_q;
  logic       resp_q, rd_q;
  logic [7:0] cart_q, breg_q;

  sysmem_addr_dec i_dec (
    .addr_i   (addr_i),
    .region_o (rg)
  );

  assign rd      = req_i & ~we_i;
  assign wr      = req_i & we_i;
  assign is_cart = (rg == RG_CART);
  assign mapped  = (rg != RG_NONE) && (rg != RG_CART);

  assign vram_we  = wr && rg == RG_VRAM;
  assign vram_re  = rd && rg == RG_VRAM;
  assign wram_we  = wr && rg == RG_WRAM;
  assign wram_re  = rd && rg == RG_WRAM;
  assign oam_we   = wr && rg == RG_OAM;
  assign oam_re   = rd && rg == RG_OAM;
  assign high_we  = wr && rg == RG_HIGH;
  assign high_re  = rd && rg == RG_HIGH;
  assign wr_vbank = wr && rg == RG_VBANK;
  assign wr_wbank = wr && rg == RG_WBANK;

  sysmem_bank_sel #(.WBANK_W(WBANK_W)) i_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_vbank_i  (wr_vbank),
    .wr_wbank_i  (wr_wbank),
    .wdata_i     (wdata_i[WBANK_W-1:0]),
    .vbank_o     (vbank),
    .wbank_o     (wbank),
    .wbank_eff_o (wbank_eff)
  );

  // address bit 12 splits the work window into fixed and banked halves
  assign wram_bank = addr_i[12] ? wbank_eff : '0;
  assign vram_idx  = {vbank, addr_i[VRAM_AW-1:0]};
  assign wram_idx  = {wram_bank, addr_i[WRAM_AW-1:0]};

  sysmem_byte_ram #(.DEPTH(VRAM_DEPTH), .CLEAR_RST(1'b0)) i_vram (
    .clk_i (clk_i), .rst_ni (rst_ni), .we_i (vram_we), .re_i (vram_re),
    .addr_i (vram_idx), .wdata_i (wdata_i), .rdata_o (vram_q)
  );

  sysmem_byte_ram #(.DEPTH(WRAM_DEPTH), .CLEAR_RST(1'b0)) i_wram (
    .clk_i (clk_i), .rst_ni (rst_ni), .we_i (wram_we), .re_i (wram_re),
    .addr_i (wram_idx), .wdata_i (wdata_i), .rdata_o (wram_q)
  );

  sysmem_byte_ram #(.DEPTH(OAM_BYTES), .CLEAR_RST(1'b0)) i_oam (
    .clk_i (clk_i), .rst_ni (rst_ni), .we_i (oam_we), .re_i (oam_re),
    .addr_i (addr_i[7:0]), .wdata_i (wdata_i), .rdata_o (oam_q)
  );

  sysmem_byte_ram #(.DEPTH(HIGH_BYTES), .CLEAR_RST(1'b1)) i_high (
    .clk_i (clk_i), .rst_ni (rst_ni), .we_i (high_we), .re_i (high_re),
    .addr_i (addr_i[7:0]), .wdata_i (wdata_i), .rdata_o (high_q)
  );

  assign cart_req_o   = req_i & is_cart;
  assign cart_we_o    = wr & is_cart;
  assign cart_addr_o  = addr_i;
  assign cart_wdata_o = wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_q <= 1'b0;
      rd_q   <= 1'b0;
      rg_q   <= RG_NONE;
      cart_q <= 8'h00;
      breg_q <= 8'h00;
    end else begin
      resp_q <= req_i && (mapped || (is_cart && cart_ack_i));
      rd_q   <= rd;
      rg_q   <= rg;
      if (rd && is_cart)       cart_q <= cart_rdata_i;
      if (rd && rg == RG_VBANK) breg_q <= {7'b0, vbank};
      if (rd && rg == RG_WBANK) breg_q <= 8'(wbank);
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (resp_q && rd_q) begin
      unique case (rg_q)
        RG_CART:            rdata_o = cart_q;
        RG_VRAM:            rdata_o = vram_q;
        RG_WRAM:            rdata_o = wram_q;
        RG_OAM:             rdata_o = oam_q;
        RG_HIGH:            rdata_o = high_q;
        RG_VBANK, RG_WBANK: rdata_o = breg_q;
        default:            rdata_o = 8'h00;
      endcase
    end
  end

  assign resp_o = resp_q;

  a_r1_idle_no_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !resp_o);
  a_r7_illegal_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i >= 16'hFEA0 && addr_i <= 16'hFEFF) |=> !resp_o && rdata_o == 8'h00);
  a_r8_unmapped_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i >= 16'hE000 && addr_i <= 16'hFDFF) |=> !resp_o);
  a_r2_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({vram_we, wram_we, oam_we, high_we, wr_vbank, wr_wbank, cart_we_o}));
endmodule

// File: tb/test_sysmem_decode.sv
module test_sysmem_decode;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        resp_o;
  logic [7:0]  rdata_o;
  logic        cart_req_o, cart_we_o;
  logic [15:0] cart_addr_o;
  logic [7:0]  cart_wdata_o;
  logic        cart_ack_en = 1'b1;
  logic        cart_ack_i;
  logic [7:0]  cart_rdata_i;

  int errors = 0;
  int checks = 0;
  logic       got_resp;
  logic [7:0] got_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  // mapper model
  assign cart_ack_i   = cart_ack_en & cart_req_o;
  assign cart_rdata_i = cart_addr_o[15:8] ^ cart_addr_o[7:0] ^ 8'h5A;

  sysmem_decode i_sysmem_decode (
    .clk_i (clk), .rst_ni (rst_ni), .req_i (req), .we_i (we),
    .addr_i (addr), .wdata_i (wdata), .resp_o (resp_o), .rdata_o (rdata_o),
    .cart_req_o (cart_req_o), .cart_we_o (cart_we_o), .cart_addr_o (cart_addr_o),
    .cart_wdata_o (cart_wdata_o), .cart_ack_i (cart_ack_i), .cart_rdata_i (cart_rdata_i)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    got_resp = resp_o;
    got_data = rdata_o;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
    acc(1'b0, a, 8'h00);
    chk({tag, " resp"}, 32'(got_resp), 32'd1);
    chk({tag, " data"}, 32'(got_data), 32'(exp));
  endtask

  task automatic wr_chk(input string tag, input logic [15:0] a, input logic [7:0] d,
                        input logic exp_resp);
    acc(1'b1, a, d);
    chk({tag, " wresp"}, 32'(got_resp), 32'(exp_resp));
  endtask

  function automatic logic exp_mapped(input int a);
    return (a <= 'h9FFF) || (a >= 'hA000 && a <= 'hDFFF) ||
           (a >= 'hFE00 && a <= 'hFE9F) || (a >= 'hFF00);
  endfunction

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 / R1: reset state
    chk("R1 reset resp", 32'(resp_o), 32'd0);
    chk("R1 reset rdata", 32'(rdata_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 idle resp", 32'(resp_o), 32'd0);

    // full read sweep: classification (R1,R2,R7,R8), reset contents (R11)
    for (int a = 0; a <= 65536; a++) begin
      @(negedge clk);
      if (a > 0) begin
        int p;
        p = a - 1;
        chk($sformatf("R1 sweep resp %04h", p), 32'(resp_o), 32'(exp_mapped(p)));
        if ((p <= 'h7FFF) || (p >= 'hA000 && p <= 'hBFFF))
          chk($sformatf("R2 sweep cart data %04h", p), 32'(rdata_o),
              32'(p[15:8] ^ p[7:0] ^ 8'h5A));
        else if (p >= 'hFF00)
          chk($sformatf("R11 sweep high clear %04h", p), 32'(rdata_o), 32'd0);
        else if (!exp_mapped(p))
          chk($sformatf("R1 sweep silent data %04h", p), 32'(rdata_o), 32'd0);
      end
      if (a < 65536) begin
        req = 1'b1; we = 1'b0; addr = a[15:0];
      end else begin
        req = 1'b0;
      end
    end

    // R2: cartridge write forwarding in the request cycle
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 16'hA123; wdata = 8'h44;
    #1;
    chk("R2 cart_req", 32'(cart_req_o), 32'd1);
    chk("R2 cart_we", 32'(cart_we_o), 32'd1);
    chk("R2 cart_addr", 32'(cart_addr_o), 32'hA123);
    chk("R2 cart_wdata", 32'(cart_wdata_o), 32'h44);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk("R2 cart write resp", 32'(resp_o), 32'd1);
    // R2: mapper refuses
    cart_ack_en = 1'b0;
    acc(1'b0, 16'h1234, 8'h00);
    chk("R2 no ack resp", 32'(got_resp), 32'd0);
    cart_ack_en = 1'b1;
    // R2: write outside cartridge does not request mapper
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 16'hC001; wdata = 8'h00;
    #1;
    chk("R2 no cart_req off range", 32'(cart_req_o), 32'd0);
    @(negedge clk);
    req = 1'b0; we = 1'b0;

    // R3: video banks
    wr_chk("R10 vbank0", 16'hFF6E, 8'h00, 1'b1);
    wr_chk("R3 vram b0", 16'h8010, 8'h11, 1'b1);
    wr_chk("R10 vbank1", 16'hFF6E, 8'h01, 1'b1);
    wr_chk("R3 vram b1", 16'h8010, 8'h22, 1'b1);
    rd_chk("R3 vram read b1", 16'h8010, 8'h22);
    wr_chk("R10 vbank0 again", 16'hFF6E, 8'h00, 1'b1);
    rd_chk("R3 vram read b0", 16'h8010, 8'h11);

    // R5: work bank 0 selects bank 1
    wr_chk("R10 wbank0", 16'hFF6F, 8'h00, 1'b1);
    wr_chk("R5 wram via 0", 16'hD005, 8'hA1, 1'b1);
    wr_chk("R10 wbank1", 16'hFF6F, 8'h01, 1'b1);
    rd_chk("R5 zero aliases one", 16'hD005, 8'hA1);
    wr_chk("R10 wbank3", 16'hFF6F, 8'h03, 1'b1);
    wr_chk("R5 wram b3", 16'hD005, 8'hB3, 1'b1);
    rd_chk("R5 wram read b3", 16'hD005, 8'hB3);
    wr_chk("R10 wbank1 again", 16'hFF6F, 8'h01, 1'b1);
    rd_chk("R5 wram b1 kept", 16'hD005, 8'hA1);
    // R4: fixed lower half
    wr_chk("R4 wram low", 16'hC005, 8'hC0, 1'b1);
    wr_chk("R10 wbank6", 16'hFF6F, 8'h06, 1'b1);
    rd_chk("R4 low fixed", 16'hC005, 8'hC0);

    // R10: masking and readback
    wr_chk("R10 wbank ff", 16'hFF6F, 8'hFF, 1'b1);
    rd_chk("R10 wbank readback", 16'hFF6F, 8'h07);
    wr_chk("R10 vbank fe", 16'hFF6E, 8'hFE, 1'b1);
    rd_chk("R10 vbank readback", 16'hFF6E, 8'h00);
    wr_chk("R10 vbank ff", 16'hFF6E, 8'hFF, 1'b1);
    rd_chk("R10 vbank readback 1", 16'hFF6E, 8'h01);
    rd_chk("R3 vram b1 after mask", 16'h8010, 8'h22);

    // R6: object attribute store
    wr_chk("R6 oam last", 16'hFE9F, 8'h5E, 1'b1);
    wr_chk("R6 oam first", 16'hFE00, 8'h01, 1'b1);
    rd_chk("R6 oam last rd", 16'hFE9F, 8'h5E);
    rd_chk("R6 oam first rd", 16'hFE00, 8'h01);

    // R7: illegal hole
    wr_chk("R7 illegal write", 16'hFEA5, 8'h77, 1'b0);
    wr_chk("R7 illegal write edge", 16'hFEFF, 8'h78, 1'b0);
    acc(1'b0, 16'hFEA5, 8'h00);
    chk("R7 illegal read resp", 32'(got_resp), 32'd0);
    chk("R7 illegal read data", 32'(got_data), 32'd0);
    rd_chk("R7 high untouched", 16'hFFA5, 8'h00);
    rd_chk("R7 high edge untouched", 16'hFFFF, 8'h00);
    rd_chk("R7 oam untouched", 16'hFE9F, 8'h5E);

    // R8: unmapped
    wr_chk("R8 unmapped E000", 16'hE000, 8'h12, 1'b0);
    wr_chk("R8 unmapped FDFF", 16'hFDFF, 8'h13, 1'b0);
    rd_chk("R8 wram not echoed", 16'hC005, 8'hC0);

    // R9: high store
    wr_chk("R9 high ff80", 16'hFF80, 8'h9C, 1'b1);
    wr_chk("R9 high ff00", 16'hFF00, 8'h3D, 1'b1);
    wr_chk("R9 high ffff", 16'hFFFF, 8'hE1, 1'b1);
    rd_chk("R9 read ff80", 16'hFF80, 8'h9C);
    rd_chk("R9 read ff00", 16'hFF00, 8'h3D);
    rd_chk("R9 read ffff", 16'hFFFF, 8'hE1);
    rd_chk("R9 neighbour clear", 16'hFF81, 8'h00);

    // R11: second reset clears high store and bank registers
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    rd_chk("R11 high cleared", 16'hFF80, 8'h00);
    rd_chk("R11 vbank cleared", 16'hFF6E, 8'h00);
    rd_chk("R11 wbank cleared", 16'hFF6F, 8'h00);

    finish_up();
  end
endmodule